// File: doc/BRIEF.md
# Shared-Line Interrupt Router

This block steers eight level-sensitive PCI interrupt request lines and one ACPI system control interrupt (SCI) onto a vector of global system interrupt (GSI) outputs. Each request line has its own routing byte. When that byte enables routing, the line drives a chosen legacy PIC input. Whatever the byte holds, the line also drives its own dedicated APIC input above the PIC range. Several request lines may share one PIC input, and the input then carries the OR of all of them.

A control byte picks which GSI carries the SCI, or leaves the SCI unconnected. When that choice changes while the SCI is asserted, the old line drops and the new line rises only after one cycle in which the SCI drives neither, so no line ever sees a glitch. Software writes the routing and control bytes through a simple byte write port. Each write to a routing byte produces a one-cycle route-changed pulse. A combinational query port reports where a chosen request line currently lands.

Top module: `pirq_router`

## Requirements
- R1: After reset every GSI output and `route_chg` are low, every routing byte is 0x80 (routing disabled), and the SCI select code is 0.
- R2: A routing byte uses bits [4:0] for the PIC IRQ number and bit 7 as the disable flag. Write addresses 0 to 3 select request lines A to D, addresses 4 to 7 select lines E to H, and address 8 selects the SCI control byte. A line with its flag clear and an IRQ number below 16 drives PIC output bit equal to that number.
- R3: Request line i always drives GSI output bit 16+i, whether its routing is enabled or not.
- R4: When several enabled request lines target the same PIC input, that output is the OR of those lines.
- R5: A request line that is enabled with an IRQ number of 16 or more drives no PIC output.
- R6: Bits [2:0] of the SCI control byte select the SCI target: 0 gives GSI 9, 1 gives GSI 10, 2 gives GSI 11, 4 gives GSI 20 and 5 gives GSI 21. Any other code leaves the SCI unconnected. The SCI is ORed onto its target together with any other source.
- R7: If the SCI is high at the edge where a control write changes the decoded target, the next output cycle has the SCI on no line, and the cycle after that has it on the new line.
- R8: The query port reports, for line `rq_sel`, `rq_en`=1 and `rq_irq`=16+`rq_sel` when routing is disabled; `rq_en`=1 and `rq_irq`=the IRQ number when routing is enabled below 16; and `rq_en`=0 and `rq_irq`=0 when routing is enabled at 16 or above.
- R9: `route_chg` is high for exactly the cycle after a write to addresses 0 to 7, and a write to address 8 does not raise it.
- R10: `gsi_out` is registered. It reflects the inputs sampled at each clock edge, a register write takes effect on the edge after the write, and with no source active all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pirq_in | input | 8 | Level request lines A (bit 0) to H (bit 7) |
| sci_in | input | 1 | SCI level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0 to 7 routing bytes, 8 SCI control |
| wr_data | input | 8 | Write data |
| rq_sel | input | 3 | Request line being queried |
| gsi_out | output | 24 | GSI levels, 0 to 15 PIC, 16 to 23 APIC |
| route_chg | output | 1 | One-cycle pulse after a routing byte write |
| rq_en | output | 1 | Queried route is active |
| rq_irq | output | 5 | GSI number of the queried route |

## Verification
On every cycle the assertions check that each request line appears on its dedicated APIC output one edge later. They also check that all outputs fall quiet when no source is active, that `route_chg` only follows a routing-byte write, and that query results stay consistent between the disabled and the out-of-range cases. Only the bench scenarios can show that the routing bytes reach the right PIC inputs, that shared lines combine, and that each SCI code decodes to its GSI. The same holds for the one-cycle gap when the SCI moves while asserted, which the bench checks against the exact cycle in which it must appear.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NPIRQ    = 8,
  parameter int PIC_PINS = 16,
  parameter int IRQ_W    = 5,
  parameter int SEL_W    = 3,
  parameter int ADDR_W   = 4,
  localparam int NGSI    = PIC_PINS + NPIRQ,
  localparam int GSI_W   = $clog2(NGSI),
  localparam int PW      = $clog2(NPIRQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIRQ-1:0]  pirq_in,
  input  logic              sci_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [PW-1:0]     rq_sel,
  output logic [NGSI-1:0]   gsi_out,
  output logic              route_chg,
  output logic              rq_en,
  output logic [GSI_W-1:0]  rq_irq
);

  logic [7:0]       rt [NPIRQ];
  logic [SEL_W-1:0] sci_sel;
  logic             gap_q;
  logic [NGSI-1:0]  nx;

  function automatic logic [GSI_W:0] sci_dec(input logic [SEL_W-1:0] s);
    case (s)
      SEL_W'(0): sci_dec = {1'b1, GSI_W'(9)};
      SEL_W'(1): sci_dec = {1'b1, GSI_W'(10)};
      SEL_W'(2): sci_dec = {1'b1, GSI_W'(11)};
      SEL_W'(4): sci_dec = {1'b1, GSI_W'(20)};
      SEL_W'(5): sci_dec = {1'b1, GSI_W'(21)};
      default:   sci_dec = '0;
    endcase
  endfunction

  wire [GSI_W:0] cur_sci = sci_dec(sci_sel);
  wire [GSI_W:0] new_sci = sci_dec(wr_data[SEL_W-1:0]);
  wire wr_rt  = wr_en && (int'(wr_addr) < NPIRQ);
  wire wr_ctl = wr_en && (int'(wr_addr) == NPIRQ);

  always_comb begin
    nx = '0;
    for (int i = 0; i < NPIRQ; i++) begin
      if (!rt[i][7] && int'(rt[i][IRQ_W-1:0]) < PIC_PINS)
        nx[rt[i][IRQ_W-1:0]] = nx[rt[i][IRQ_W-1:0]] | pirq_in[i];
      nx[PIC_PINS+i] = nx[PIC_PINS+i] | pirq_in[i];
    end
    if (cur_sci[GSI_W] && sci_in && !gap_q)
      nx[cur_sci[GSI_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIRQ; i++) rt[i] <= 8'h80;
      sci_sel   <= '0;
      gap_q     <= 1'b0;
      gsi_out   <= '0;
      route_chg <= 1'b0;
    end else begin
      if (wr_rt) rt[wr_addr[PW-1:0]] <= wr_data;
      if (wr_ctl) sci_sel <= wr_data[SEL_W-1:0];
      gap_q     <= wr_ctl && sci_in && (new_sci != cur_sci);
      gsi_out   <= nx;
      route_chg <= wr_rt;
    end
  end

  wire [7:0] q_rt  = rt[rq_sel];
  wire       q_low = int'(q_rt[IRQ_W-1:0]) < PIC_PINS;

  assign rq_en  = q_rt[7] | q_low;
  assign rq_irq = q_rt[7] ? GSI_W'(PIC_PINS + int'(rq_sel))
                : (q_low ? GSI_W'(q_rt[IRQ_W-1:0]) : '0);

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NPIRQ    = 8,
  parameter int PIC_PINS = 16,
  parameter int ADDR_W   = 4,
  localparam int NGSI    = PIC_PINS + NPIRQ,
  localparam int GSI_W   = $clog2(NGSI),
  localparam int PW      = $clog2(NPIRQ)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPIRQ-1:0]  pirq_in,
  input logic              sci_in,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PW-1:0]     rq_sel,
  input logic [NGSI-1:0]   gsi_out,
  input logic              route_chg,
  input logic              rq_en,
  input logic [GSI_W-1:0]  rq_irq
);

  p_apic_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((gsi_out[NGSI-1:PIC_PINS] & $past(pirq_in)) == $past(pirq_in)));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_in && pirq_in == '0) |=> gsi_out == '0);

  p_route_chg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    route_chg |-> $past(wr_en && int'(wr_addr) < NPIRQ));

  p_route_apic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_en && int'(rq_irq) >= PIC_PINS) |-> int'(rq_irq) == PIC_PINS + int'(rq_sel));

  p_route_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rq_en |-> rq_irq == '0);

endmodule

bind pirq_router pirq_router_chk #(.NPIRQ(NPIRQ), .PIC_PINS(PIC_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in), .wr_en(wr_en),
  .wr_addr(wr_addr), .rq_sel(rq_sel), .gsi_out(gsi_out), .route_chg(route_chg),
  .rq_en(rq_en), .rq_irq(rq_irq)
);

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] pirq_in = '0;
  logic sci_in = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rq_sel = '0;
  logic [23:0] gsi_out;
  logic route_chg, rq_en;
  logic [4:0] rq_irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rt_m [8];
  logic [2:0] sel_m;
  bit gap_m;

  always #2.5 clk = ~clk;

  pirq_router u0 (.clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rq_sel(rq_sel),
    .gsi_out(gsi_out), .route_chg(route_chg), .rq_en(rq_en), .rq_irq(rq_irq));

  function automatic int sci_target(input logic [2:0] s);
    case (s)
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd4: return 20;
      3'd5: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [23:0] model(input logic [7:0] p, input logic s);
    logic [23:0] e = '0;
    for (int i = 0; i < 8; i++) begin
      if (!rt_m[i][7] && rt_m[i][4:0] < 5'd16 && p[i]) e[rt_m[i][3:0]] = 1'b1;
      if (p[i]) e[16+i] = 1'b1;
    end
    if (s && sci_target(sel_m) >= 0) e[sci_target(sel_m)] = 1'b1;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] p, input logic s, input string req);
    pirq_in = p;
    sci_in = s;
    exp_q.push_back(model(p, s && !gap_m));
    tag_q.push_back(req);
    gap_m = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a == 4'd8) begin
      if (sci_in && sci_target(d[2:0]) != sci_target(sel_m)) gap_m = 1;
      sel_m = d[2:0];
    end else begin
      rt_m[a[2:0]] = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
    check(route_chg == (a < 4'd8), "R9 route_chg", route_chg, a < 4'd8);
  endtask

  task automatic query(input logic [2:0] s, input logic e_en, input logic [4:0] e_irq, input string req);
    rq_sel = s;
    #0.1;
    check(rq_en == e_en && rq_irq == e_irq, req, {rq_en, rq_irq}, {e_en, e_irq});
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [23:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(gsi_out == e, t, gsi_out, e);
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) rt_m[i] = 8'h80;
    sel_m = 0; gap_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(gsi_out == 0, "R1 gsi reset", gsi_out, 0);
    check(route_chg == 0, "R1 route_chg reset", route_chg, 0);
    for (int i = 0; i < 8; i++) query(3'(i), 1'b1, 5'(16 + i), "R1 R8 disabled route");

    drive(8'h01, 0, "R3 apic only");
    drive(8'h00, 1, "R1 R6 default SCI on 9");
    drive(8'h00, 0, "R10 quiet");

    wr(4'd0, 8'h05);
    drive(8'h01, 0, "R2 A to 5");
    wr(4'd5, 8'h05);
    drive(8'h20, 0, "R4 F to 5");
    drive(8'h21, 0, "R4 shared line");
    drive(8'h00, 0, "R10 quiet");
    query(3'd0, 1'b1, 5'd5, "R8 enabled low");

    wr(4'd2, 8'h13);
    query(3'd2, 1'b0, 5'd0, "R8 R5 out of range");
    drive(8'h04, 0, "R5 no PIC line");
    wr(4'd6, 8'h8C);
    drive(8'h40, 0, "R2 disable flag set");

    wr(4'd8, 8'h04);
    drive(8'h00, 1, "R6 SCI on 20");
    drive(8'h10, 1, "R6 SCI OR with APIC line");
    wr(4'd8, 8'h05);
    drive(8'h00, 1, "R7 gap cycle");
    drive(8'h00, 1, "R7 SCI on 21");
    wr(4'd8, 8'h03);
    drive(8'h00, 1, "R7 gap to none");
    drive(8'h00, 1, "R6 SCI unconnected");
    wr(4'd8, 8'h01);
    drive(8'h00, 1, "R7 gap from none");
    drive(8'h00, 1, "R6 SCI on 10");
    drive(8'h00, 0, "R10 SCI low");
    wr(4'd8, 8'h02);
    drive(8'h00, 1, "R6 R7 no gap SCI on 11");
    wr(4'd0, 8'h0B);
    drive(8'h01, 1, "R6 SCI shared with A");
    drive(8'h01, 0, "R4 A alone on 11");
    drive(8'h00, 0, "R10 quiet");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule